// File: doc/BRIEF.md
# Fractional-N Multi-Modulus Divider Controller

This block steers an external multi-ratio prescaler in the feedback path of a fractional-N synthesizer. It runs on the divided prescaler clock, so every clock edge marks one prescaler output period. A signed cycle counter walks through up to four ratio phases per main cycle. The two select outputs tell the prescaler which ratio to use in each period. A pulse marks the last period of every main cycle, and that pulse drives the phase comparator.

A 3-bit fractional accumulator adds a programmed increment once per main cycle. It wraps at 5 or at 8. When it wraps, the following main cycle gives one period of the first ratio to the second ratio instead. Because the second ratio is one above the first, the division rises by one for that cycle. Over many cycles the mean division gains a fraction of increment over modulus. The accumulator value is exported so that a compensation circuit can use it.

New ratio settings are captured when requested but only take effect at the boundary between main cycles, so the divider phase never jumps. An enable input parks the block.

Top module: `frac_mmd_ctrl`

## Requirements
- R1: The select pair {sel1,sel2} is 2'b10 during first-ratio periods, 2'b00 during second-ratio periods, 2'b01 during third-ratio periods and 2'b11 during fourth-ratio periods.
- R2: Without a wrap, a main cycle has nm1+2 first-ratio periods, then nm2 second-ratio periods (none when nm2 is 0), then nm3+1 third-ratio periods and nm4+1 fourth-ratio periods for the phases in use, in that order.
- R3: In the main cycle after an accumulator wrap, the first-ratio phase is one period shorter (nm1+1) and the second-ratio phase is one period longer (nm2+1).
- R4: The 2-bit mode code selects the phases: 01 uses the first and second only; 10 adds the third; 11 uses all four; 00 uses first, second and fourth and skips the third.
- R5: The second-phase count uses all 8 bits of nm2 in mode 01 and only nm2[3:0] in the other modes.
- R6: cyc_pulse is high for exactly the last period of every main cycle and low otherwise.
- R7: At the edge that ends a main cycle, frac_state becomes (frac_state+frac_inc) minus the modulus (8 when frac_mod8=1, 5 when 0) if the sum reaches the modulus, or the plain sum otherwise. A wrap is defined as the sum reaching the modulus. frac_inc is kept below the modulus. frac_state changes at no other edge while enabled.
- R8: A load request captures the new nm1, nm2, nm3, nm4 and mode. The capture is applied at the edge that ends the current main cycle; a request in that same period is applied directly. ld_done is high for the one period after the applying edge. A load never changes frac_state.
- R9: While en is low, the selects show 2'b10, cyc_pulse is low, and frac_state is cleared at the next edge. Each edge restarts the counter at the start of a main cycle, and a pending or new load is applied at the next edge.
- R10: After reset, the selects show 2'b10, cyc_pulse, ld_done and frac_state are 0, and the work settings are nm1=0, nm2=0, nm3=0, nm4=0, mode 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided prescaler clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Divider enable |
| ld_req | input | 1 | Request to take new ratio settings |
| ld_nm1 | input | 12 | New first-phase count |
| ld_nm2 | input | 8 | New second-phase count |
| ld_nm3 | input | 4 | New third-phase count |
| ld_nm4 | input | 4 | New fourth-phase count |
| ld_mode | input | 2 | New phase-selection mode |
| frac_inc | input | 3 | Fractional increment per main cycle |
| frac_mod8 | input | 1 | Accumulator modulus: 1 = 8, 0 = 5 |
| sel1 | output | 1 | Prescaler select bit 1 |
| sel2 | output | 1 | Prescaler select bit 2 |
| cyc_pulse | output | 1 | High in the last period of a main cycle |
| frac_state | output | 3 | Current accumulator value |
| ld_done | output | 1 | One-period pulse after a load is applied |

## Verification
Two events can fall on the same edge: a load request and the end of a main cycle. The accumulator update, and with it a wrap, can also land on the very boundary at which a load takes effect. The stimulus issues periodic load requests with varied settings across many short cycles, so a number of them land exactly in the last period of a cycle. A behavioural model rebuilds the expected select sequence at each boundary. Each coincidence is judged by comparing, every period, the first cycle under the new settings, including its wrap-shortened shape, and the timing of ld_done against that model.

// File: rtl/frac_mmd_ctrl.sv
module frac_mmd_ctrl #(
  parameter int NM1_W = 12,
  parameter int NM2_W = 8,
  parameter int NMX_W = 4,
  parameter int ACC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ld_req,
  input  logic [NM1_W-1:0] ld_nm1,
  input  logic [NM2_W-1:0] ld_nm2,
  input  logic [NMX_W-1:0] ld_nm3,
  input  logic [NMX_W-1:0] ld_nm4,
  input  logic [1:0]       ld_mode,
  input  logic [ACC_W-1:0] frac_inc,
  input  logic             frac_mod8,
  output logic             sel1,
  output logic             sel2,
  output logic             cyc_pulse,
  output logic [ACC_W-1:0] frac_state,
  output logic             ld_done
);
  localparam int CW = NM1_W + 1;

  typedef enum logic [1:0] {PH1 = 2'b10, PH2 = 2'b00, PH3 = 2'b01, PH4 = 2'b11} phase_t;

  phase_t ph, ph_n;
  logic signed [CW-1:0] cnt, cnt_n;
  logic [NM1_W-1:0] nm1_w, nm1_s, nm1_src, nm1_nx;
  logic [NM2_W-1:0] nm2_w, nm2_s, nm2_src, nm2_e;
  logic [NMX_W-1:0] nm3_w, nm3_s, nm3_src, nm4_w, nm4_s, nm4_src;
  logic [1:0] mode_w, mode_s, mode_src;
  logic pend, ovf, cyc_end, boundary, apply, has3, has4, r2_empty;
  logic [ACC_W:0] sum, modq;
  logic wrap;
  logic signed [CW-1:0] end1, start2, e2s, e3s, e4s;

  assign has3     = mode_w[1];
  assign has4     = (mode_w[1] == mode_w[0]);
  assign nm2_e    = (mode_w == 2'b01) ? nm2_w : {{(NM2_W-NMX_W){1'b0}}, nm2_w[NMX_W-1:0]};
  assign r2_empty = !ovf && (nm2_e == '0);
  assign end1     = ovf ? '1 : '0;
  assign start2   = ovf ? '0 : CW'(1);
  assign e2s      = {{(CW-NM2_W){1'b0}}, nm2_e};
  assign e3s      = {{(CW-NMX_W){1'b0}}, nm3_w};
  assign e4s      = {{(CW-NMX_W){1'b0}}, nm4_w};

  always_comb begin
    ph_n    = ph;
    cnt_n   = cnt + CW'(1);
    cyc_end = 1'b0;
    case (ph)
      PH1: if (cnt == end1) begin
        if (!r2_empty) begin ph_n = PH2; cnt_n = start2; end
        else if (has3) begin ph_n = PH3; cnt_n = '0; end
        else if (has4) begin ph_n = PH4; cnt_n = '0; end
        else cyc_end = 1'b1;
      end
      PH2: if (cnt == e2s) begin
        if (has3) begin ph_n = PH3; cnt_n = '0; end
        else if (has4) begin ph_n = PH4; cnt_n = '0; end
        else cyc_end = 1'b1;
      end
      PH3: if (cnt == e3s) begin
        if (has4) begin ph_n = PH4; cnt_n = '0; end
        else cyc_end = 1'b1;
      end
      default: if (cnt == e4s) cyc_end = 1'b1;
    endcase
  end

  assign boundary = !en || cyc_end;
  assign apply    = boundary && (pend || ld_req);
  assign nm1_src  = ld_req ? ld_nm1  : nm1_s;
  assign nm2_src  = ld_req ? ld_nm2  : nm2_s;
  assign nm3_src  = ld_req ? ld_nm3  : nm3_s;
  assign nm4_src  = ld_req ? ld_nm4  : nm4_s;
  assign mode_src = ld_req ? ld_mode : mode_s;
  assign nm1_nx   = apply ? nm1_src : nm1_w;

  assign sum  = {1'b0, frac_state} + {1'b0, frac_inc};
  assign modq = frac_mod8 ? (ACC_W+1)'(8) : (ACC_W+1)'(5);
  assign wrap = (sum >= modq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH1; cnt <= '1;
      nm1_w <= '0; nm2_w <= '0; nm3_w <= '0; nm4_w <= '0; mode_w <= 2'b01;
      nm1_s <= '0; nm2_s <= '0; nm3_s <= '0; nm4_s <= '0; mode_s <= 2'b01;
      pend <= 1'b0; ovf <= 1'b0; frac_state <= '0; ld_done <= 1'b0;
    end else begin
      ld_done <= apply;
      if (apply) begin
        nm1_w <= nm1_src; nm2_w <= nm2_src; nm3_w <= nm3_src; nm4_w <= nm4_src; mode_w <= mode_src;
        pend <= 1'b0;
      end else if (ld_req) begin
        nm1_s <= ld_nm1; nm2_s <= ld_nm2; nm3_s <= ld_nm3; nm4_s <= ld_nm4; mode_s <= ld_mode;
        pend <= 1'b1;
      end
      if (!en) begin
        frac_state <= '0; ovf <= 1'b0;
      end else if (cyc_end) begin
        frac_state <= wrap ? ACC_W'(sum - modq) : ACC_W'(sum);
        ovf <= wrap;
      end
      if (boundary) begin
        ph <= PH1; cnt <= ~{1'b0, nm1_nx};
      end else begin
        ph <= ph_n; cnt <= cnt_n;
      end
    end
  end

  assign {sel1, sel2} = en ? ph : 2'b10;
  assign cyc_pulse    = en && cyc_end;

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cyc_pulse) |=> (!en || ({sel1, sel2} == 2'b10)));
  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_pulse |=> !cyc_pulse);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cyc_pulse) |=> (!en || $stable(frac_state)));
  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> $past(cyc_pulse || !en));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (frac_state == '0));
endmodule

// File: tb/frac_mmd_ctrl_test.sv
module frac_mmd_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, ld_req = 1'b0, frac_mod8 = 1'b1;
  logic [11:0] ld_nm1 = '0;
  logic [7:0]  ld_nm2 = '0;
  logic [3:0]  ld_nm3 = '0, ld_nm4 = '0;
  logic [1:0]  ld_mode = 2'b01;
  logic [2:0]  frac_inc = '0;
  logic sel1, sel2, cyc_pulse, ld_done;
  logic [2:0] frac_state;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  frac_mmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en(en), .ld_req(ld_req),
    .ld_nm1(ld_nm1), .ld_nm2(ld_nm2), .ld_nm3(ld_nm3), .ld_nm4(ld_nm4), .ld_mode(ld_mode),
    .frac_inc(frac_inc), .frac_mod8(frac_mod8),
    .sel1(sel1), .sel2(sel2), .cyc_pulse(cyc_pulse), .frac_state(frac_state), .ld_done(ld_done));

  logic [1:0] q[$];
  int w1 = 0, w2 = 0, w3 = 0, w4 = 0, wm = 1;
  int s1 = 0, s2 = 0, s3 = 0, s4 = 0, sm = 1;
  int m_frd = 0;
  bit m_ovf = 0, m_pend = 0, m_done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rebuild();
    int e2, n1, n2, n3, n4;
    q.delete();
    e2 = (wm == 1) ? w2 : (w2 & 15);
    n1 = m_ovf ? w1 + 1 : w1 + 2;
    n2 = m_ovf ? e2 + 1 : e2;
    n3 = (wm == 2 || wm == 3) ? w3 + 1 : 0;
    n4 = (wm == 3 || wm == 0) ? w4 + 1 : 0;
    for (int i = 0; i < n1; i++) q.push_back(2'b10);
    for (int i = 0; i < n2; i++) q.push_back(2'b00);
    for (int i = 0; i < n3; i++) q.push_back(2'b01);
    for (int i = 0; i < n4; i++) q.push_back(2'b11);
  endtask

  task automatic stim(input int c);
    ld_req = 1'b0;
    if (c == 10) begin en = 1; ld_req = 1; ld_nm1 = 3; ld_nm2 = 2; ld_mode = 2'b01; frac_inc = 0; frac_mod8 = 1; end
    if (c == 40) begin frac_inc = 3; frac_mod8 = 0; end
    if (c == 120) begin ld_req = 1; ld_nm1 = 2; ld_nm2 = 5; ld_nm3 = 3; ld_mode = 2'b10; end
    if (c == 250) begin ld_req = 1; ld_nm4 = 2; ld_mode = 2'b11; end
    if (c == 400) begin ld_req = 1; ld_nm2 = 8'h13; ld_mode = 2'b00; frac_inc = 2; frac_mod8 = 1; end
    if (c == 550) begin ld_req = 1; ld_nm1 = 1; ld_nm2 = 8'hC0; ld_mode = 2'b01; frac_inc = 5; end
    if (c == 1500) en = 0;
    if (c == 1502) begin ld_req = 1; ld_nm1 = 0; ld_nm2 = 0; ld_mode = 2'b01; frac_inc = 7; end
    if (c == 1506) en = 1;
    if (c >= 1600 && c % 37 == 0) begin
      ld_req = 1; ld_nm1 = 12'(c % 5); ld_nm2 = 8'(c % 7 + 16 * (c % 2));
      ld_nm3 = 4'(c % 3); ld_nm4 = 4'(c % 4); ld_mode = 2'(c % 4);
    end
    if (c >= 1600) begin
      frac_mod8 = ((c / 100) % 2) == 1;
      frac_inc = frac_mod8 ? 3'((c / 50) % 8) : 3'((c / 50) % 5);
    end
    if (c >= 2400 && c < 2403) en = 0;
  endtask

  task automatic advance();
    bit bnd, app, at_end;
    at_end = en && (q.size() == 1);
    bnd = !en || at_end;
    app = bnd && (m_pend || ld_req);
    if (app) begin
      if (ld_req) begin w1 = ld_nm1; w2 = ld_nm2; w3 = ld_nm3; w4 = ld_nm4; wm = ld_mode; end
      else begin w1 = s1; w2 = s2; w3 = s3; w4 = s4; wm = sm; end
      m_pend = 0;
    end else if (ld_req) begin
      s1 = ld_nm1; s2 = ld_nm2; s3 = ld_nm3; s4 = ld_nm4; sm = ld_mode; m_pend = 1;
    end
    m_done = app;
    if (!en) begin m_frd = 0; m_ovf = 0; end
    else if (at_end) begin
      int s, qm;
      s = m_frd + frac_inc; qm = frac_mod8 ? 8 : 5;
      if (s >= qm) begin m_frd = (s - qm) & 7; m_ovf = 1; end
      else begin m_frd = s; m_ovf = 0; end
    end
    if (bnd) rebuild(); else void'(q.pop_front());
  endtask

  initial begin
    rebuild();
    repeat (3) @(negedge clk);
    #1;
    chk("R10 sel", {sel1, sel2}, 2);
    chk("R10 cyc_pulse", cyc_pulse, 0);
    chk("R10 frac_state", frac_state, 0);
    chk("R10 ld_done", ld_done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 2700; c++) begin
      string tg;
      if (c > 0) @(negedge clk);
      stim(c);
      #1;
      if (!en) tg = "R1 R9";
      else if (m_ovf) tg = "R1 R3";
      else if (wm == 0) tg = "R1 R4";
      else if (wm == 1 && w2 > 15) tg = "R1 R5";
      else tg = "R1 R2";
      chk(tg, {sel1, sel2}, en ? int'(q[0]) : 2);
      chk("R6 cyc_pulse", cyc_pulse, (en && q.size() == 1) ? 1 : 0);
      chk("R7 frac_state", frac_state, m_frd);
      chk("R8 ld_done", ld_done, m_done);
      advance();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule